// File: doc/BRIEF.md
# Decimating Coefficient-RAM FIR Filter

This block is a programmable FIR filter that decimates. It takes signed 20-bit samples and returns signed 20-bit samples. The coefficients are signed 14-bit words held in a 64-word RAM. One multiply-accumulate unit computes each output serially, one step per clock, and computes one output for every N accepted inputs, where N is the decimation rate.

The tap count and the decimation rate are given as the value minus one. A start offset into the coefficient RAM selects the active filter, so several filters can be held in the RAM at once and switched between computations. A decimation phase picks which input of each period starts an output, so several instances can split one carrier polyphase-style. A symmetry flag folds the impulse response, which doubles the reach from 64 to 128 taps. A 2-bit scale word selects attenuation by right shift, and a bypass flag hands each input straight to the output.

Top module: `decim_ram_fir`

## Requirements
- R1: While reset is held and after it is released, out_valid is low until a filtered or bypassed result is produced. Every sample older than the first accepted one counts as zero, and the phase slot starts at 0.
- R2: When coef_wr_en is high at a clock edge, the signed 14-bit coef_wr_data is written to the 6-bit coef_wr_addr. Every later computation uses the new word.
- R3: With cfg_sym low, the result for trigger input x[n] is the sum over i from 0 to T-1 of h[i]·x[n-i], where h[i] = RAM[(offset+i) mod 64]. T is cfg_taps_m1+1, limited to 64.
- R4: With cfg_sym high, h[i] = RAM[(offset+min(i,T-1-i)) mod 64] and T reaches 128. Only ceil(T/2) words are read.
- R5: A phase slot advances on every accepted input. It returns to 0 after it reaches cfg_rate_m1 or any higher value. An output is computed for the input accepted while the slot equals the effective phase. The rate is cfg_rate_m1+1, from 1 to 16.
- R6: The effective phase is cfg_phase modulo the rate, so a phase at or above the rate wraps around.
- R7: The offset, tap count, symmetry and scale are captured with the triggering input. A change made while a computation runs affects only the next one. Coefficient addresses wrap modulo 64.
- R8: The sum is shifted right arithmetically by 16 minus cfg_scale, then saturated to the range from -524288 to 524287. With code 3 (0 dB), a coefficient of 8192 has unit gain. Codes 2, 1 and 0 each halve the result once more.
- R9: With cfg_bypass high, every input appears unchanged and unscaled on out_data, with out_valid, right after the edge that captures it. The filter starts no computation, but the sample history and the phase slot still advance.
- R10: A filtered result is a one-cycle out_valid pulse, S clock edges after the capture edge. S is T when cfg_sym is low and ceil(T/2) when it is high. No triggering input may arrive while a computation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_wr_en | input | 1 | Coefficient write strobe |
| coef_wr_addr | input | 6 | Coefficient RAM write address |
| coef_wr_data | input | 14 | Signed coefficient word |
| cfg_taps_m1 | input | 7 | Tap count minus one |
| cfg_rate_m1 | input | 4 | Decimation rate minus one |
| cfg_offset | input | 6 | RAM address of the active filter's first coefficient |
| cfg_phase | input | 4 | Decimation phase |
| cfg_sym | input | 1 | Folded (symmetric) response |
| cfg_bypass | input | 1 | Pass inputs through unfiltered |
| cfg_scale | input | 2 | Output attenuation code |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 20 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 20 | Signed output sample |

## Verification
Some rules hold on every cycle, and the in-design properties check them there: the phase slot never exceeds the rate just seen, the step counter stays within the captured step count, the coefficient address walks by one per step and wraps, bypass returns each input on the next cycle, and no trigger arrives while a computation runs. The arithmetic can only be shown by the directed scenarios, which compare each output with an independent sum over the sample history. These cover the folded coefficient indexing for odd and even tap counts, the clamp at 64 taps, the scale codes with saturation at both rails, offset switching in the middle of a computation, and which inputs are kept for a given phase and rate.

// File: rtl/dfir_pkg.sv
`timescale 1ns/1ps
package dfir_pkg;

  localparam int SAMPLE_W  = 20;
  localparam int COEF_W    = 14;
  localparam int COEF_FRAC = COEF_W - 1;
  localparam int SCALE_TOP = 3;

  // Shift a wide sum down by the coefficient fraction plus the attenuation
  // chosen by code, then clip to a signed out_w-bit range.
  function automatic logic signed [63:0] scale_and_clip(
    input logic signed [63:0] acc,
    input logic [1:0]         code,
    input int                 frac,
    input int                 out_w
  );
    logic signed [63:0] shifted;
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    int                 sh;
    sh      = frac + SCALE_TOP - int'(code);
    shifted = acc >>> sh;
    hi      = (64'sd1 <<< (out_w - 1)) - 64'sd1;
    lo      = -hi - 64'sd1;
    if (shifted > hi) return hi;
    if (shifted < lo) return lo;
    return shifted;
  endfunction

endpackage

// File: rtl/dfir_coef_ram.sv
`timescale 1ns/1ps
module dfir_coef_ram #(
  parameter int COEF_W = 14,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic signed [COEF_W-1:0] rd_data
);

  logic signed [COEF_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/dfir_history.sv
`timescale 1ns/1ps
module dfir_history #(
  parameter int DW    = 20,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic signed [DW-1:0] wr_data,
  output logic [AW-1:0]        wr_ptr,
  input  logic [AW-1:0]        rd_addr_a,
  input  logic [AW-1:0]        rd_addr_b,
  output logic signed [DW-1:0] rd_data_a,
  output logic signed [DW-1:0] rd_data_b
);

  logic signed [DW-1:0] line_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
      wr_ptr <= '0;
    end else if (wr_en) begin
      line_q[wr_ptr] <= wr_data;
      wr_ptr         <= wr_ptr + 1'b1;
    end
  end

  assign rd_data_a = line_q[rd_addr_a];
  assign rd_data_b = line_q[rd_addr_b];

endmodule

// File: rtl/dfir_decim_ctrl.sv
`timescale 1ns/1ps
module dfir_decim_ctrl #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [RW-1:0] rate_m1,
  input  logic [RW-1:0] phase,
  output logic          trig
);

  logic [RW-1:0] slot;
  logic [RW:0]   rate;
  logic [RW:0]   phase_eff;

  assign rate      = {1'b0, rate_m1} + 1'b1;
  assign phase_eff = {1'b0, phase} % rate;
  assign trig      = in_valid && ({1'b0, slot} == phase_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (in_valid) begin
      slot <= (slot >= rate_m1) ? '0 : slot + 1'b1;
    end
  end

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> slot <= $past(rate_m1));

endmodule

// File: rtl/dfir_mac.sv
`timescale 1ns/1ps
module dfir_mac #(
  parameter int DW     = 20,
  parameter int CW     = 14,
  parameter int CDEPTH = 64,
  parameter int FRAC   = 13,
  localparam int HDEPTH = 2 * CDEPTH,
  localparam int HAW    = $clog2(HDEPTH),
  localparam int CAW    = $clog2(CDEPTH),
  localparam int PW     = DW + 1 + CW,
  localparam int ACC_W  = PW + HAW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [HAW-1:0]       base,
  input  logic [HAW-1:0]       taps_m1,
  input  logic                 sym,
  input  logic [CAW-1:0]       offset,
  input  logic [1:0]           scale,
  output logic [HAW-1:0]       hist_addr_a,
  output logic [HAW-1:0]       hist_addr_b,
  input  logic signed [DW-1:0] hist_a,
  input  logic signed [DW-1:0] hist_b,
  output logic [CAW-1:0]       coef_addr,
  input  logic signed [CW-1:0] coef,
  output logic                 res_valid,
  output logic signed [DW-1:0] res_data
);

  logic                    busy;
  logic                    done;
  logic [HAW-1:0]          step;
  logic [HAW-1:0]          base_q;
  logic [HAW-1:0]          tm1_q;
  logic [HAW-1:0]          last_q;
  logic                    sym_q;
  logic [CAW-1:0]          off_q;
  logic [1:0]              scale_q;
  logic [HAW-1:0]          eff_m1;
  logic [HAW-1:0]          last_d;
  logic [HAW-1:0]          mirror;
  logic                    use_b;
  logic signed [DW:0]      pre;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_nx;

  // Clamp the unfolded tap count to the RAM depth; fold halves the steps.
  always_comb begin
    eff_m1 = taps_m1;
    if (!sym && (taps_m1 > HAW'(CDEPTH - 1))) eff_m1 = HAW'(CDEPTH - 1);
    last_d = sym ? (eff_m1 >> 1) : eff_m1;
  end

  assign mirror      = tm1_q - step;
  assign hist_addr_a = base_q - step;
  assign hist_addr_b = base_q - mirror;
  assign use_b       = sym_q && (mirror != step);
  assign coef_addr   = off_q + step[CAW-1:0];
  assign done        = busy && (step == last_q);

  assign pre    = $signed({hist_a[DW-1], hist_a})
                + (use_b ? $signed({hist_b[DW-1], hist_b}) : $signed({(DW + 1){1'b0}}));
  assign prod   = pre * coef;
  assign acc_nx = acc + $signed({{HAW{prod[PW-1]}}, prod});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      acc       <= '0;
      base_q    <= '0;
      tm1_q     <= '0;
      last_q    <= '0;
      sym_q     <= 1'b0;
      off_q     <= '0;
      scale_q   <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        step    <= '0;
        acc     <= '0;
        base_q  <= base;
        tm1_q   <= eff_m1;
        last_q  <= last_d;
        sym_q   <= sym;
        off_q   <= offset;
        scale_q <= scale;
      end else if (busy) begin
        acc  <= acc_nx;
        step <= step + 1'b1;
        if (done) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_data  <= DW'(dfir_pkg::scale_and_clip(
                         $signed({{(64 - ACC_W){acc_nx[ACC_W-1]}}, acc_nx}),
                         scale_q, FRAC, DW));
        end
      end
    end
  end

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && busy));

  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step <= last_q);

  // R7
  coef_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> coef_addr == $past(coef_addr) + 1'b1);

endmodule

// File: rtl/decim_ram_fir.sv
`timescale 1ns/1ps
module decim_ram_fir #(
  parameter int DATA_W     = dfir_pkg::SAMPLE_W,
  parameter int COEF_W     = dfir_pkg::COEF_W,
  parameter int COEF_DEPTH = 64,
  parameter int RATE_W     = 4,
  localparam int TAP_W     = $clog2(2 * COEF_DEPTH),
  localparam int CAW       = $clog2(COEF_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     coef_wr_en,
  input  logic [CAW-1:0]           coef_wr_addr,
  input  logic signed [COEF_W-1:0] coef_wr_data,
  input  logic [TAP_W-1:0]         cfg_taps_m1,
  input  logic [RATE_W-1:0]        cfg_rate_m1,
  input  logic [CAW-1:0]           cfg_offset,
  input  logic [RATE_W-1:0]        cfg_phase,
  input  logic                     cfg_sym,
  input  logic                     cfg_bypass,
  input  logic [1:0]               cfg_scale,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);

  logic [TAP_W-1:0]         wr_ptr;
  logic [TAP_W-1:0]         hist_addr_a;
  logic [TAP_W-1:0]         hist_addr_b;
  logic signed [DATA_W-1:0] hist_a;
  logic signed [DATA_W-1:0] hist_b;
  logic [CAW-1:0]           coef_rd_addr;
  logic signed [COEF_W-1:0] coef_rd;
  logic                     trig;
  logic                     mac_start;
  logic                     res_valid;
  logic signed [DATA_W-1:0] res_data;
  logic                     byp_valid;
  logic signed [DATA_W-1:0] byp_data;

  dfir_coef_ram #(.COEF_W(COEF_W), .DEPTH(COEF_DEPTH)) coef_ram_i (
    .clk     (clk),
    .wr_en   (coef_wr_en),
    .wr_addr (coef_wr_addr),
    .wr_data (coef_wr_data),
    .rd_addr (coef_rd_addr),
    .rd_data (coef_rd)
  );

  dfir_history #(.DW(DATA_W), .DEPTH(2 * COEF_DEPTH)) history_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (in_valid),
    .wr_data   (in_data),
    .wr_ptr    (wr_ptr),
    .rd_addr_a (hist_addr_a),
    .rd_addr_b (hist_addr_b),
    .rd_data_a (hist_a),
    .rd_data_b (hist_b)
  );

  dfir_decim_ctrl #(.RW(RATE_W)) decim_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rate_m1  (cfg_rate_m1),
    .phase    (cfg_phase),
    .trig     (trig)
  );

  assign mac_start = trig && !cfg_bypass;

  dfir_mac #(
    .DW(DATA_W), .CW(COEF_W), .CDEPTH(COEF_DEPTH), .FRAC(COEF_W - 1)
  ) mac_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (mac_start),
    .base        (wr_ptr),
    .taps_m1     (cfg_taps_m1),
    .sym         (cfg_sym),
    .offset      (cfg_offset),
    .scale       (cfg_scale),
    .hist_addr_a (hist_addr_a),
    .hist_addr_b (hist_addr_b),
    .hist_a      (hist_a),
    .hist_b      (hist_b),
    .coef_addr   (coef_rd_addr),
    .coef        (coef_rd),
    .res_valid   (res_valid),
    .res_data    (res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_valid <= 1'b0;
      byp_data  <= '0;
    end else begin
      byp_valid <= in_valid;
      byp_data  <= in_data;
    end
  end

  assign out_valid = cfg_bypass ? byp_valid : res_valid;
  assign out_data  = cfg_bypass ? byp_data  : res_data;

  // R9
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && in_valid) |=> (!cfg_bypass || (out_valid && out_data == $past(in_data))));

endmodule

// File: tb/decim_ram_fir_tb.sv
`timescale 1ns/1ps
module decim_ram_fir_tb_top;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               coef_wr_en;
  logic [5:0]         coef_wr_addr;
  logic signed [13:0] coef_wr_data;
  logic [6:0]         taps_m1;
  logic [3:0]         rate_m1;
  logic [5:0]         offset;
  logic [3:0]         phase;
  logic               sym;
  logic               byp;
  logic [1:0]         scale;
  logic               in_valid;
  logic signed [19:0] in_data;
  logic               out_valid;
  logic signed [19:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int cm [64];
  int hx [0:8191];
  int hn = 0;
  int mcnt = 0;

  always #2 clk = ~clk;

  decim_ram_fir dut_i (
    .clk(clk), .rst_n(rst_n),
    .coef_wr_en(coef_wr_en), .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
    .cfg_taps_m1(taps_m1), .cfg_rate_m1(rate_m1), .cfg_offset(offset), .cfg_phase(phase),
    .cfg_sym(sym), .cfg_bypass(byp), .cfg_scale(scale),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wr_coef(input int addr, input int val);
    @(negedge clk);
    coef_wr_en   = 1'b1;
    coef_wr_addr = addr[5:0];
    coef_wr_data = val[13:0];
    cm[addr]     = val;
    @(negedge clk);
    coef_wr_en   = 1'b0;
  endtask

  // Sends one sample, predicts from the requirements whether and when an
  // output appears and its value, then watches the output for 72 cycles.
  task automatic send(input int x, input string req, input int new_off = -1);
    int rate, ph, n, t, s, first_k, seen;
    bit tr;
    longint acc, y, got;
    rate = int'(rate_m1) + 1;
    ph   = int'(phase) % rate;
    tr   = byp || (mcnt == ph);
    n    = hn;
    hx[n] = x;
    hn++;
    y = 0; s = 0;
    if (byp) begin
      y = x;
      s = 0;
    end else begin
      t = int'(taps_m1) + 1;
      if (!sym && t > 64) t = 64;
      acc = 0;
      for (int i = 0; i < t; i++) begin
        int ci, xi;
        ci = (sym && (t - 1 - i) < i) ? (t - 1 - i) : i;
        xi = (n - i >= 0) ? hx[n - i] : 0;
        acc += longint'(cm[(int'(offset) + ci) % 64]) * longint'(xi);
      end
      y = acc >>> (16 - int'(scale));
      if (y > 524287) y = 524287;
      if (y < -524288) y = -524288;
      s = sym ? (t + 1) / 2 : t;
    end
    mcnt = (mcnt >= int'(rate_m1)) ? 0 : mcnt + 1;

    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[19:0];
    @(negedge clk);
    in_valid = 1'b0;
    first_k = -1; seen = 0; got = 0;
    for (int k = 0; k <= 72; k++) begin
      if (k > 0) @(negedge clk);
      if (out_valid) begin
        seen++;
        if (first_k < 0) begin
          first_k = k;
          got = longint'(out_data);
        end
      end
      if (k == 2 && new_off >= 0) offset = new_off[5:0];
    end
    if (tr) begin
      check(seen == 1, "R5 one output per kept input", seen, 1);
      check(first_k == s, byp ? "R9 bypass latency" : "R10 result latency", first_k, s);
      check(got == y, req, got, y);
    end else begin
      check(seen == 0, "R5 skipped input gives no output", seen, 0);
    end
  endtask

  task automatic rnd_send(input int amp, input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      int v;
      v = int'($urandom_range(0, 2 * amp)) - amp;
      send(v, req);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid low after reset", out_valid, 0);
    end
  endtask

  task automatic t_impulse();
    for (int i = 0; i < 64; i++) wr_coef(i, ((i * 37) % 97 - 48) * 60);
    taps_m1 = 7; rate_m1 = 0; phase = 0; sym = 0; scale = 3; offset = 0;
    // R2 R3: unit impulse returns the stored words one by one
    send(8192, "R2 impulse returns coefficient");
    for (int i = 0; i < 9; i++) send(0, "R3 impulse tail");
  endtask

  task automatic t_decim();
    taps_m1 = 19; rate_m1 = 2; phase = 1; scale = 1;
    rnd_send(20000, 30, "R5 decimated output value");
  endtask

  task automatic t_phase();
    taps_m1 = 11; rate_m1 = 3; phase = 7; scale = 2;
    rnd_send(20000, 16, "R6 wrapped phase output");
    rate_m1 = 15; phase = 0;
    rnd_send(20000, 34, "R5 rate 16 output");
  endtask

  task automatic t_sym();
    sym = 1; rate_m1 = 0; phase = 0; scale = 0;
    taps_m1 = 14;
    rnd_send(5000, 20, "R4 folded 15 taps");
    taps_m1 = 15;
    rnd_send(5000, 20, "R4 folded 16 taps");
    taps_m1 = 127;
    rnd_send(5000, 20, "R4 folded 128 taps");
    sym = 0;
  endtask

  task automatic t_clamp();
    sym = 0; taps_m1 = 100; rate_m1 = 0; scale = 0;
    rnd_send(5000, 12, "R3 asymmetric clamp to 64");
  endtask

  task automatic t_offset();
    for (int j = 0; j < 8; j++) wr_coef(32 + j, ((j % 2) ? -1 : 1) * (j + 1) * 500);
    taps_m1 = 7; rate_m1 = 0; phase = 0; scale = 3; offset = 32;
    send(8192, "R7 second filter impulse");
    send(0, "R7 second filter tail");
    send(0, "R7 change mid computation", 0);
    for (int i = 0; i < 6; i++) send(0, "R7 first filter after switch");
    offset = 60;
    send(8192, "R7 offset wraps modulo 64");
    for (int i = 0; i < 8; i++) send(0, "R7 wrap tail");
  endtask

  task automatic t_scale();
    taps_m1 = 0; rate_m1 = 0; phase = 0; offset = 0; sym = 0;
    wr_coef(0, 5000);
    for (int c = 0; c < 4; c++) begin
      scale = c[1:0];
      send(100000, "R8 scale code shift");
    end
    taps_m1 = 1; scale = 3;
    wr_coef(0, 8191); wr_coef(1, 8191);
    send(524287, "R8 positive sum");
    send(524287, "R8 saturate high");
    send(-524288, "R8 mixed sum");
    send(-524288, "R8 saturate low");
  endtask

  task automatic t_bypass();
    byp = 1; rate_m1 = 5; phase = 2; scale = 0;
    send(123456, "R9 bypass value");
    send(-77, "R9 bypass value");
    send(-524288, "R9 bypass no scaling");
    send(524287, "R9 bypass no scaling");
    send(0, "R9 bypass value");
    byp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 200000, 0);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; coef_wr_en = 1'b0; coef_wr_addr = '0; coef_wr_data = '0;
    taps_m1 = '0; rate_m1 = '0; offset = '0; phase = '0; sym = 1'b0; byp = 1'b0;
    scale = 2'd3; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid low in reset", out_valid, 0);
    rst_n = 1'b1;
    t_reset();
    t_impulse();
    t_decim();
    t_phase();
    t_sym();
    t_clamp();
    t_offset();
    t_scale();
    t_bypass();
    summary();
  end

endmodule